// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a first-in first-out buffer built as a chain of single-word stages rather than as a memory with pointers. A word written at the input stage advances one stage per clock toward the output stage, moving only into a stage that is empty. When the output stage is read, the slot it leaves behind travels back toward the input one stage per clock. Both latencies are therefore visible at the ports: a word written into an empty buffer is not readable until it has crossed every stage, and a read from a full buffer does not free the input until the hole has crossed every stage.

The write side has a shift strobe (`shift_in`) and a ready flag (`in_ready`). The read side has a shift strobe (`shift_out`) and a ready flag (`out_ready`). A transfer takes place on a clock edge where the strobe and the matching flag are both high, and the flag then drops for at least one cycle. Holding a strobe high therefore gives one transfer per flag pulse, which is how automatic loading and unloading work. Two instances chain with plain wires to form a buffer of twice the depth. The upstream `out_ready` drives the downstream `shift_in`. The downstream `in_ready` drives the upstream `shift_out`. The upstream `dout` drives the downstream `din`. An output enable gates the data outputs to zero and lowers a drive flag that stands in for a high-impedance state.

Top module: `fallthru_fifo`

## Requirements
- R1: With default parameters the buffer holds exactly 64 words of 5 bits. After 64 writes with no read, `in_ready` stays low.
- R2: An active-low `rst_n` empties the buffer at once. After reset is released, `in_ready` is 1 and `out_ready` is 0, and no word appears later unless one is written.
- R3: A word is taken from `din` on a rising clock edge where `shift_in` and `in_ready` are both 1. `in_ready` is 0 in the cycle after every such edge.
- R4: A word accepted into an empty buffer on edge k raises `out_ready` after edge k+63 (DEPTH-1 stage advances) and not before. `dout` then carries that word.
- R5: The output stage is emptied on a rising edge where `shift_out` and `out_ready` are both 1. `out_ready` is 0 in the cycle after every such edge. A read of the last word leaves `out_ready` low.
- R6: In a full buffer, a read on edge p raises `in_ready` after edge p+63 and not before. `out_ready` returns after edge p+1 with the next word.
- R7: Words leave in the order they entered, with none lost and none repeated.
- R8: A strobe held high makes one transfer each time its flag rises. `in_ready` never falls unless a word was written, and `out_ready` never falls unless a word was read.
- R9: With `out_en` at 0, `dout` is all zero and `dout_drive` is 0. With `out_en` at 1, `dout_drive` is 1 and `dout` shows the output stage word.
- R10: Two instances chained as described form a 128-word buffer that keeps order with no loss or duplication, under continuous strobes on both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset; empties all stages |
| shift_in | input | 1 | Write strobe, acted on while `in_ready` is high |
| din | input | WIDTH | Word to write |
| in_ready | output | 1 | Input stage is empty and can take a word |
| shift_out | input | 1 | Read strobe, acted on while `out_ready` is high |
| out_ready | output | 1 | Output stage holds a word |
| out_en | input | 1 | Output enable for `dout` |
| dout | output | WIDTH | Output stage word, zero when disabled |
| dout_drive | output | 1 | High when `dout` is being driven |

## Verification
The bench measures both latencies to the exact edge. A stage rule that lets a word skip a stage, or that waits an extra cycle, moves `out_ready` or `in_ready` off the counted edge. Held strobes are used at both ends, including a write strobe held while the buffer is full, so a design that takes a word twice per flag pulse, or takes one into a full input stage, shows up as an extra or corrupted word in the drained sequence. The two-instance cascade is filled to exactly 128 words and then streamed with both strobes held. A handshake that moves zero or two words per transfer loses or duplicates words, and the bench catches this in the read order and the final counts. A reset in mid-run with words in flight must leave nothing to fall through afterwards.

// File: rtl/fallthru_pkg.sv
package fallthru_pkg;

    localparam int unsigned DEF_WIDTH = 5;
    localparam int unsigned DEF_DEPTH = 64;

    // Transfers decided for the current clock edge
    typedef struct packed {
        logic push;   // a word enters the input stage
        logic pop;    // the output stage is emptied
    } xfer_t;

endpackage

// File: rtl/fallthru_stage.sv
module fallthru_stage #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_avail,
    input  logic [WIDTH-1:0] in_data,
    input  logic             out_free,
    output logic             valid,
    output logic [WIDTH-1:0] data
);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } slot_t;

    slot_t slot_d;
    slot_t slot_q;

    always_comb begin
        slot_d = slot_q;
        // the held word moves on when the next place is free
        if (slot_q.valid && out_free) begin
            slot_d.valid = 1'b0;
        end
        // an empty slot takes the word offered from upstream
        if (!slot_q.valid && in_avail) begin
            slot_d.valid = 1'b1;
            slot_d.data  = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign data  = slot_q.data;

endmodule

// File: rtl/fallthru_hs.sv
module fallthru_hs
    import fallthru_pkg::*;
(
    input  logic  shift_in,
    input  logic  shift_out,
    input  logic  head_valid,
    input  logic  tail_valid,
    output logic  in_ready,
    output logic  out_ready,
    output xfer_t xfer
);

    always_comb begin
        in_ready  = !head_valid;
        out_ready = tail_valid;
        xfer.push = shift_in  && !head_valid;
        xfer.pop  = shift_out && tail_valid;
    end

endmodule

// File: rtl/fallthru_odrv.sv
module fallthru_odrv #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             out_en,
    input  logic [WIDTH-1:0] tail_data,
    output logic [WIDTH-1:0] dout,
    output logic             dout_drive
);

    always_comb begin
        dout_drive = out_en;
        dout       = out_en ? tail_data : '0;
    end

endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
    import fallthru_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    output logic             out_ready,
    input  logic             out_en,
    output logic [WIDTH-1:0] dout,
    output logic             dout_drive
);

    localparam int LAST = DEPTH - 1;

    logic             stg_valid [DEPTH];
    logic [WIDTH-1:0] stg_data  [DEPTH];
    xfer_t            xfer;

    fallthru_hs u_hs (
        .shift_in   (shift_in),
        .shift_out  (shift_out),
        .head_valid (stg_valid[0]),
        .tail_valid (stg_valid[LAST]),
        .in_ready   (in_ready),
        .out_ready  (out_ready),
        .xfer       (xfer)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic             avail;
        logic [WIDTH-1:0] src;
        logic             free;

        if (i == 0) begin : g_head
            assign avail = xfer.push;
            assign src   = din;
        end else begin : g_body
            assign avail = stg_valid[i-1];
            assign src   = stg_data[i-1];
        end

        if (i == LAST) begin : g_tail
            assign free = xfer.pop;
        end else begin : g_mid
            assign free = !stg_valid[i+1];
        end

        fallthru_stage #(.WIDTH(WIDTH)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_avail (avail),
            .in_data  (src),
            .out_free (free),
            .valid    (stg_valid[i]),
            .data     (stg_data[i])
        );
    end

    fallthru_odrv #(.WIDTH(WIDTH)) u_odrv (
        .out_en     (out_en),
        .tail_data  (stg_data[LAST]),
        .dout       (dout),
        .dout_drive (dout_drive)
    );

endmodule

// File: rtl/fallthru_fifo_chk.sv
module fallthru_fifo_chk #(
    parameter int unsigned WIDTH = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_in,
    input logic             in_ready,
    input logic             shift_out,
    input logic             out_ready,
    input logic             out_en,
    input logic [WIDTH-1:0] dout,
    input logic             dout_drive
);

    // R2
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_ready));

    // R3
    write_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_in && in_ready) |=> !in_ready);

    // R5
    read_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_out && out_ready) |=> !out_ready);

    // R8
    in_ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !shift_in) |=> in_ready);

    // R8
    out_ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !shift_out) |=> out_ready);

    // R9
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (dout == '0 && !dout_drive));

    // R9
    enabled_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> dout_drive);

endmodule

bind fallthru_fifo fallthru_fifo_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_in   (shift_in),
    .in_ready   (in_ready),
    .shift_out  (shift_out),
    .out_ready  (out_ready),
    .out_en     (out_en),
    .dout       (dout),
    .dout_drive (dout_drive)
);

// File: tb/fallthru_fifo_tb_top.sv
module fallthru_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       shift_in = 1'b0;
    logic [4:0] din = '0;
    logic       in_ready;
    logic       shift_out = 1'b0;
    logic       out_ready;
    logic       out_en = 1'b1;
    logic [4:0] dout;
    logic       dout_drive;

    // cascade pair
    logic       c_si = 1'b0;
    logic [4:0] c_din = '0;
    logic       c_so = 1'b0;
    logic       up_in_ready, up_out_ready, up_drive;
    logic [4:0] up_dout;
    logic       dn_in_ready, dn_out_ready, dn_drive;
    logic [4:0] dn_dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fallthru_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din),
        .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
        .out_en(out_en), .dout(dout), .dout_drive(dout_drive)
    );

    fallthru_fifo casc_up (
        .clk(clk), .rst_n(rst_n), .shift_in(c_si), .din(c_din),
        .in_ready(up_in_ready), .shift_out(dn_in_ready), .out_ready(up_out_ready),
        .out_en(1'b1), .dout(up_dout), .dout_drive(up_drive)
    );

    fallthru_fifo casc_dn (
        .clk(clk), .rst_n(rst_n), .shift_in(up_out_ready), .din(up_dout),
        .in_ready(dn_in_ready), .shift_out(c_so), .out_ready(dn_out_ready),
        .out_en(1'b1), .dout(dn_dout), .dout_drive(dn_drive)
    );

    function automatic logic [4:0] wa(int n);
        return 5'((n * 7 + 3) % 32);
    endfunction

    function automatic logic [4:0] wc(int n);
        return 5'((n * 11 + 5) % 32);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(in_ready == 1'b1, "R2 in_ready after reset", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R2 out_ready after reset", int'(out_ready), 0);
        chk(dout_drive == 1'b1, "R9 drive with out_en high", int'(dout_drive), 1);
    endtask

    task automatic t_latency;
        int early = 0;
        shift_in = 1'b1;
        din = 5'h15;
        @(negedge clk);           // edge k accepted the word
        shift_in = 1'b0;
        chk(in_ready == 1'b0, "R3 in_ready low after write", int'(in_ready), 0);
        repeat (62) begin
            @(negedge clk);
            if (out_ready) early++;
        end
        chk(early == 0, "R4 out_ready before k+63", early, 0);
        @(negedge clk);
        chk(out_ready == 1'b1, "R4 out_ready at k+63", int'(out_ready), 1);
        chk(dout == 5'h15, "R4 word at output", int'(dout), 'h15);
    endtask

    task automatic t_read_last;
        int seen = 0;
        shift_out = 1'b1;
        @(negedge clk);
        shift_out = 1'b0;
        chk(out_ready == 1'b0, "R5 out_ready low after read", int'(out_ready), 0);
        repeat (80) begin
            @(negedge clk);
            if (out_ready) seen++;
        end
        chk(seen == 0, "R5 empty after last read", seen, 0);
    endtask

    task automatic t_fill;
        int cnt = 0;
        int g = 0;
        int hi = 0;
        while (cnt < 64 && g < 1000) begin
            if (in_ready) begin
                shift_in = 1'b1;
                din = wa(cnt);
                cnt++;
            end else begin
                shift_in = 1'b0;
            end
            @(negedge clk);
            g++;
        end
        shift_in = 1'b0;
        repeat (140) begin
            @(negedge clk);
            if (in_ready) hi++;
        end
        chk(cnt == 64, "R1 words accepted", cnt, 64);
        chk(hi == 0, "R1 in_ready stays low when full", hi, 0);
        chk(out_ready == 1'b1, "R7 first word ready", int'(out_ready), 1);
        chk(dout == wa(0), "R7 first word value", int'(dout), int'(wa(0)));
    endtask

    task automatic t_outen;
        out_en = 1'b0;
        #1;
        chk(dout == 5'd0, "R9 dout zero when disabled", int'(dout), 0);
        chk(dout_drive == 1'b0, "R9 drive low when disabled", int'(dout_drive), 0);
        out_en = 1'b1;
        #1;
        chk(dout == wa(0), "R9 dout restored", int'(dout), int'(wa(0)));
    endtask

    task automatic t_bubble;
        int early = 0;
        shift_in = 1'b1;           // held while full
        din = 5'h1E;
        shift_out = 1'b1;
        @(negedge clk);           // edge p
        shift_out = 1'b0;
        chk(out_ready == 1'b0, "R5 out_ready low after read", int'(out_ready), 0);
        @(negedge clk);           // after p+1
        chk(out_ready == 1'b1, "R6 next word refills", int'(out_ready), 1);
        chk(dout == wa(1), "R7 second word", int'(dout), int'(wa(1)));
        if (in_ready) early++;
        repeat (61) begin
            @(negedge clk);
            if (in_ready) early++;
        end
        chk(early == 0, "R6 in_ready before p+63", early, 0);
        @(negedge clk);           // after p+63
        chk(in_ready == 1'b1, "R6 in_ready at p+63", int'(in_ready), 1);
        @(negedge clk);           // held strobe took a word
        chk(in_ready == 1'b0, "R8 held shift_in took word", int'(in_ready), 0);
        shift_in = 1'b0;
    endtask

    task automatic t_drain;
        int rd = 0;
        int g = 0;
        int bad = 0;
        int extra = 0;
        logic [4:0] exp;
        shift_out = 1'b1;          // held
        while (rd < 64 && g < 2000) begin
            if (out_ready) begin
                exp = (rd < 63) ? wa(rd + 1) : 5'h1E;
                if (dout != exp) begin
                    if (bad == 0)
                        chk(1'b0, "R7 drain order", int'(dout), int'(exp));
                    bad++;
                end
                rd++;
            end
            @(negedge clk);
            g++;
        end
        repeat (150) begin
            @(negedge clk);
            if (out_ready) extra++;
        end
        shift_out = 1'b0;
        chk(rd == 64, "R8 held shift_out drained all", rd, 64);
        chk(bad == 0, "R7 words in order", bad, 0);
        chk(extra == 0, "R7 no repeated word", extra, 0);
    endtask

    task automatic t_reset_mid;
        int seen = 0;
        for (int n = 0; n < 3; n++) begin
            shift_in = 1'b1;
            din = wa(n);
            @(negedge clk);
            shift_in = 1'b0;
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(in_ready == 1'b1, "R2 in_ready after mid reset", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R2 out_ready after mid reset", int'(out_ready), 0);
        repeat (80) begin
            @(negedge clk);
            if (out_ready) seen++;
        end
        chk(seen == 0, "R2 no word after mid reset", seen, 0);
    endtask

    task automatic t_cascade;
        int wr = 0;
        int rd = 0;
        int g = 0;
        int hi = 0;
        int bad = 0;
        int extra = 0;
        while (wr < 128 && g < 2000) begin
            if (up_in_ready) begin
                c_si = 1'b1;
                c_din = wc(wr);
                wr++;
            end else begin
                c_si = 1'b0;
            end
            @(negedge clk);
            g++;
        end
        c_si = 1'b0;
        repeat (400) begin
            @(negedge clk);
            if (up_in_ready) hi++;
        end
        chk(wr == 128, "R10 cascade accepted", wr, 128);
        chk(hi == 0, "R10 cascade full at 128", hi, 0);
        chk(dn_out_ready == 1'b1, "R10 cascade output ready", int'(dn_out_ready), 1);
        // stream: both strobes held/continuous
        c_so = 1'b1;
        g = 0;
        while (rd < 200 && g < 20000) begin
            if (dn_out_ready) begin
                if (dn_dout != wc(rd)) begin
                    if (bad == 0)
                        chk(1'b0, "R10 cascade order", int'(dn_dout), int'(wc(rd)));
                    bad++;
                end
                rd++;
            end
            if (up_in_ready && wr < 200) begin
                c_si = 1'b1;
                c_din = wc(wr);
                wr++;
            end else begin
                c_si = 1'b0;
            end
            @(negedge clk);
            g++;
        end
        c_si = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (dn_out_ready) extra++;
        end
        c_so = 1'b0;
        chk(rd == 200, "R10 cascade words out", rd, 200);
        chk(bad == 0, "R10 cascade in order", bad, 0);
        chk(extra == 0, "R10 cascade no duplicate", extra, 0);
    endtask

    initial begin
        #5 rst_n = 1'b0;
        t_reset();
        t_latency();
        t_read_last();
        t_fill();
        t_outen();
        t_bubble();
        t_drain();
        t_reset_mid();
        t_cascade();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule